// File: doc/BRIEF.md
# Debug Address Match Unit

This block is a bank of debug comparators placed beside a processor core. It watches the instruction-fetch stream against a set of breakpoint pairs and the load/store stream against a set of watchpoint pairs. Each pair has a value register and a control register. Software writes these registers through a small register port, which also reaches a read-only identification word and a debug status word.

A breakpoint compares the word part of the fetch address with its value register. The hit is then qualified by a per-byte select mask indexed by the two low address bits. A watchpoint builds a byte-lane mask from the access size and start byte. It hits when that mask overlaps the selected bytes of the watched word, or of the following word when the wide select field is built. Both kinds also check the current privilege mode and, for watchpoints, the access direction.

When monitor mode is on, any hit produces a one-cycle debug event, and an entry code records the cause. When halting mode is on, software cannot change the control registers.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every value register, control register and the status word read zero, and `dbg_event` and `dbg_entry` are zero.
- R2: Register op 0, index 0 reads the identification word: watchpoint pair count minus one in bits 31:28, breakpoint pair count minus one in bits 27:24, the version parameter in bits 19:16, zero elsewhere. Writes to it have no effect.
- R3: Op 4 selects breakpoint value, op 5 breakpoint control, op 6 watchpoint value and op 7 watchpoint control, with the pair chosen by the 4-bit index. A control word has enable in bit 0, privilege qualifier in bits 2:1, access type in bits 4:3 and byte select from bit 5 upward. The select is 4 bits for breakpoints and 8 bits for watchpoints when `WIDE_SEL` is 1, otherwise 4 bits. Unbuilt bits, the breakpoint type field and value bits 1:0 read zero. An index at or above the pair count ignores writes and reads zero.
- R4: A breakpoint hits on a valid fetch when it is enabled, the privilege test passes, fetch address bits 31:2 equal value bits 31:2, and the select bit numbered by fetch address bits 1:0 is set.
- R5: Privilege qualifier 1 matches only when `cpu_user` is 0, qualifier 2 only when `cpu_user` is 1, qualifier 3 in either mode, and qualifier 0 never.
- R6: A watchpoint hits on a valid data access when it is enabled, the privilege test passes, and the type admits the direction (type bit 3 admits loads, bit 4 admits stores). It also needs the access lane mask to overlap select bits 3:0 when address bits 31:2 equal the value word, or select bits 7:4 when they equal the value word plus one. The lane mask covers 1, 2 or 4 bytes for size codes 0, 1 and 2/3, starts at address bits 1:0, and is cut at the word end.
- R7: Status bit 15 (monitor enable) and bit 14 (halting enable) are written at op 0, index 1. The entry code at status bits 5:2 cannot be written. While bit 15 is clear no event is raised and the entry code does not change.
- R8: While status bit 14 is set, writes to control registers are ignored and writes to value registers still take effect.
- R9: `dbg_event` is high in the cycle after each cycle that holds a qualifying hit, and low otherwise. The entry code is 0x1 for a breakpoint, 0xA for a watchpoint on a precise access and 0x2 on an imprecise one. A breakpoint wins over a watchpoint in the same cycle.
- R10: The entry code on `dbg_entry` and in the status word holds its value until the next event.
- R11: Writing zero to a control register disables that pair for every access from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_op | input | 3 | Register group select |
| reg_idx | input | 4 | Pair index or miscellaneous register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current op and index |
| cpu_user | input | 1 | Current mode: 1 user, 0 privileged |
| fetch_valid | input | 1 | Instruction fetch present this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| dacc_valid | input | 1 | Data access present this cycle |
| dacc_addr | input | 32 | Data access byte address |
| dacc_size | input | 2 | Access size code |
| dacc_store | input | 1 | 1 for store, 0 for load |
| dacc_precise | input | 1 | 1 when the access is reported precisely |
| dbg_event | output | 1 | Debug event pulse |
| dbg_entry | output | 4 | Entry code of the last event |

## Verification
A corrupted value or control register has two visible effects. It shows up at once on `reg_rdata` when that pair is read. It also shows up as a missing or extra `dbg_event` one cycle after the next fetch or data access that falls on the affected word. A wrong entry code is seen on `dbg_entry` and in the status word the cycle after the event that caused it, and it stays visible until the next event. A stuck monitor or halting bit shows within one access (events appear or vanish) or within one control write and readback.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  localparam int unsigned DW = 32;

  localparam logic [2:0] OP_MISC = 3'd0;
  localparam logic [2:0] OP_BVAL = 3'd4;
  localparam logic [2:0] OP_BCTL = 3'd5;
  localparam logic [2:0] OP_WVAL = 3'd6;
  localparam logic [2:0] OP_WCTL = 3'd7;

  localparam logic [3:0] IDX_IDENT  = 4'd0;
  localparam logic [3:0] IDX_STATUS = 4'd1;

  localparam int unsigned CTL_EN       = 0;
  localparam int unsigned CTL_PRIV_LSB = 1;
  localparam int unsigned CTL_TYPE_LSB = 3;
  localparam int unsigned CTL_SEL_LSB  = 5;

  localparam int unsigned ST_ENTRY_LSB = 2;
  localparam int unsigned ST_HALT      = 14;
  localparam int unsigned ST_MON       = 15;

  typedef enum logic [3:0] {
    ENTRY_NONE  = 4'h0,
    ENTRY_BKPT  = 4'h1,
    ENTRY_WASYN = 4'h2,
    ENTRY_WSYN  = 4'hA
  } entry_e;

  // privilege qualifier: 1 privileged, 2 user, 3 either, 0 never
  function automatic logic mode_ok(input logic [1:0] qual, input logic user);
    logic ok;
    case (qual)
      2'd1:    ok = ~user;
      2'd2:    ok = user;
      2'd3:    ok = 1'b1;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // lanes touched inside one word, cut at the word end
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] off);
    logic [3:0] base;
    case (size)
      2'd0:    base = 4'b0001;
      2'd1:    base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << off;
  endfunction

endpackage

// File: rtl/dbg_bkpt_bank.sv
module dbg_bkpt_bank
  import dbg_match_pkg::*;
#(
  parameter int unsigned NUM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          val_we,
  input  logic          ctl_we,
  input  logic [3:0]    idx,
  input  logic [DW-1:0] wdata,
  input  logic          fetch_valid,
  input  logic [DW-1:0] fetch_addr,
  input  logic          user_mode,
  output logic          any_hit,
  output logic [DW-1:0] val_rd,
  output logic [DW-1:0] ctl_rd
);

  localparam int unsigned SEL_W = 4;
  localparam int unsigned WA_W  = DW - 2;

  logic [WA_W-1:0]  val_w  [NUM];
  logic             en_w   [NUM];
  logic [1:0]       priv_w [NUM];
  logic [SEL_W-1:0] sel_w  [NUM];
  logic [NUM-1:0]   hit_vec;

  for (genvar g = 0; g < NUM; g++) begin : g_pair
    logic             pick;
    logic             val_ld, ctl_ld;
    logic [WA_W-1:0]  val_q, val_d;
    logic             en_q, en_d;
    logic [1:0]       priv_q, priv_d;
    logic [SEL_W-1:0] sel_q, sel_d;

    assign pick   = (idx == 4'(g));
    assign val_ld = val_we & pick;
    assign ctl_ld = ctl_we & pick;

    always_comb begin
      val_d  = wdata[DW-1:2];
      en_d   = wdata[CTL_EN];
      priv_d = wdata[CTL_PRIV_LSB +: 2];
      sel_d  = wdata[CTL_SEL_LSB +: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        en_q   <= 1'b0;
        priv_q <= '0;
        sel_q  <= '0;
      end else begin
        if (val_ld) val_q <= val_d;
        if (ctl_ld) begin
          en_q   <= en_d;
          priv_q <= priv_d;
          sel_q  <= sel_d;
        end
      end
    end

    assign val_w[g]  = val_q;
    assign en_w[g]   = en_q;
    assign priv_w[g] = priv_q;
    assign sel_w[g]  = sel_q;

    assign hit_vec[g] = fetch_valid & en_q & mode_ok(priv_q, user_mode)
                      & (fetch_addr[DW-1:2] == val_q)
                      & sel_q[fetch_addr[1:0]];
  end

  assign any_hit = |hit_vec;

  always_comb begin
    val_rd = '0;
    ctl_rd = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == 4'(i)) begin
        val_rd = {val_w[i], 2'b00};
        ctl_rd = {{(DW-CTL_SEL_LSB-SEL_W){1'b0}}, sel_w[i], 2'b00, priv_w[i], en_w[i]};
      end
    end
  end

endmodule

// File: rtl/dbg_wpt_bank.sv
module dbg_wpt_bank
  import dbg_match_pkg::*;
#(
  parameter int unsigned NUM      = 2,
  parameter bit          WIDE_SEL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          val_we,
  input  logic          ctl_we,
  input  logic [3:0]    idx,
  input  logic [DW-1:0] wdata,
  input  logic          dacc_valid,
  input  logic [DW-1:0] dacc_addr,
  input  logic [1:0]    dacc_size,
  input  logic          dacc_store,
  input  logic          user_mode,
  output logic          any_hit,
  output logic [DW-1:0] val_rd,
  output logic [DW-1:0] ctl_rd
);

  localparam int unsigned SEL_W = WIDE_SEL ? 8 : 4;
  localparam int unsigned WA_W  = DW - 2;

  logic [WA_W-1:0]  val_w  [NUM];
  logic             en_w   [NUM];
  logic [1:0]       priv_w [NUM];
  logic [1:0]       type_w [NUM];
  logic [SEL_W-1:0] sel_w  [NUM];
  logic [NUM-1:0]   hit_vec;
  logic [3:0]       lanes;

  assign lanes = lane_mask(dacc_size, dacc_addr[1:0]);

  for (genvar g = 0; g < NUM; g++) begin : g_pair
    logic             pick;
    logic             val_ld, ctl_ld;
    logic [WA_W-1:0]  val_q, val_d;
    logic             en_q, en_d;
    logic [1:0]       priv_q, priv_d;
    logic [1:0]       type_q, type_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             dir_ok, lo_hit, hi_hit;

    assign pick   = (idx == 4'(g));
    assign val_ld = val_we & pick;
    assign ctl_ld = ctl_we & pick;

    always_comb begin
      val_d  = wdata[DW-1:2];
      en_d   = wdata[CTL_EN];
      priv_d = wdata[CTL_PRIV_LSB +: 2];
      type_d = wdata[CTL_TYPE_LSB +: 2];
      sel_d  = wdata[CTL_SEL_LSB +: SEL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        en_q   <= 1'b0;
        priv_q <= '0;
        type_q <= '0;
        sel_q  <= '0;
      end else begin
        if (val_ld) val_q <= val_d;
        if (ctl_ld) begin
          en_q   <= en_d;
          priv_q <= priv_d;
          type_q <= type_d;
          sel_q  <= sel_d;
        end
      end
    end

    assign dir_ok = dacc_store ? type_q[1] : type_q[0];
    assign lo_hit = (dacc_addr[DW-1:2] == val_q) & (|(lanes & sel_q[3:0]));

    if (WIDE_SEL) begin : g_wide
      logic [WA_W-1:0] next_word;
      assign next_word = val_q + WA_W'(1);
      assign hi_hit = (dacc_addr[DW-1:2] == next_word) & (|(lanes & sel_q[SEL_W-1:4]));
    end else begin : g_narrow
      assign hi_hit = 1'b0;
    end

    assign hit_vec[g] = dacc_valid & en_q & mode_ok(priv_q, user_mode)
                      & dir_ok & (lo_hit | hi_hit);

    assign val_w[g]  = val_q;
    assign en_w[g]   = en_q;
    assign priv_w[g] = priv_q;
    assign type_w[g] = type_q;
    assign sel_w[g]  = sel_q;
  end

  assign any_hit = |hit_vec;

  always_comb begin
    val_rd = '0;
    ctl_rd = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == 4'(i)) begin
        val_rd = {val_w[i], 2'b00};
        ctl_rd = {{(DW-CTL_SEL_LSB-SEL_W){1'b0}}, sel_w[i], type_w[i], priv_w[i], en_w[i]};
      end
    end
  end

endmodule

// File: rtl/dbg_event_ctl.sv
module dbg_event_ctl
  import dbg_match_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_we,
  input  logic       mon_wr,
  input  logic       halt_wr,
  input  logic       bp_hit,
  input  logic       wp_hit,
  input  logic       wp_precise,
  output logic       mon_en,
  output logic       halt_en,
  output logic       evt,
  output logic [3:0] entry
);

  logic       mon_q, halt_q, evt_q;
  logic [3:0] entry_q;
  logic       fire;
  entry_e     entry_d;

  always_comb begin
    fire = mon_q & (bp_hit | wp_hit);
    if (bp_hit)          entry_d = ENTRY_BKPT;
    else if (wp_precise) entry_d = ENTRY_WSYN;
    else                 entry_d = ENTRY_WASYN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q   <= 1'b0;
      halt_q  <= 1'b0;
      evt_q   <= 1'b0;
      entry_q <= ENTRY_NONE;
    end else begin
      evt_q <= fire;
      if (stat_we) begin
        mon_q  <= mon_wr;
        halt_q <= halt_wr;
      end
      if (fire) entry_q <= entry_d;
    end
  end

  assign mon_en  = mon_q;
  assign halt_en = halt_q;
  assign evt     = evt_q;
  assign entry   = entry_q;

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int unsigned NUM_BP   = 4,
  parameter int unsigned NUM_WP   = 2,
  parameter bit          WIDE_SEL = 1'b1,
  parameter int unsigned DBG_VER  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_op,
  input  logic [3:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cpu_user,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_addr,
  input  logic        dacc_valid,
  input  logic [31:0] dacc_addr,
  input  logic [1:0]  dacc_size,
  input  logic        dacc_store,
  input  logic        dacc_precise,
  output logic        dbg_event,
  output logic [3:0]  dbg_entry
);

  localparam logic [31:0] IDENT_WORD = {4'(NUM_WP - 1), 4'(NUM_BP - 1), 4'h0,
                                        4'(DBG_VER), 16'h0000};

  logic          mon_en, halt_en;
  logic          bp_hit, wp_hit;
  logic          bval_we, bctl_we, wval_we, wctl_we, stat_we;
  logic [DW-1:0] bval_rd, bctl_rd, wval_rd, wctl_rd;
  logic [DW-1:0] status_word;

  always_comb begin
    bval_we = reg_we & (reg_op == OP_BVAL);
    wval_we = reg_we & (reg_op == OP_WVAL);
    bctl_we = reg_we & (reg_op == OP_BCTL) & ~halt_en;
    wctl_we = reg_we & (reg_op == OP_WCTL) & ~halt_en;
    stat_we = reg_we & (reg_op == OP_MISC) & (reg_idx == IDX_STATUS);
  end

  dbg_bkpt_bank #(.NUM(NUM_BP)) bkpt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .val_we      (bval_we),
    .ctl_we      (bctl_we),
    .idx         (reg_idx),
    .wdata       (reg_wdata),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .user_mode   (cpu_user),
    .any_hit     (bp_hit),
    .val_rd      (bval_rd),
    .ctl_rd      (bctl_rd)
  );

  dbg_wpt_bank #(.NUM(NUM_WP), .WIDE_SEL(WIDE_SEL)) wpt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .val_we     (wval_we),
    .ctl_we     (wctl_we),
    .idx        (reg_idx),
    .wdata      (reg_wdata),
    .dacc_valid (dacc_valid),
    .dacc_addr  (dacc_addr),
    .dacc_size  (dacc_size),
    .dacc_store (dacc_store),
    .user_mode  (cpu_user),
    .any_hit    (wp_hit),
    .val_rd     (wval_rd),
    .ctl_rd     (wctl_rd)
  );

  dbg_event_ctl evt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_we    (stat_we),
    .mon_wr     (reg_wdata[ST_MON]),
    .halt_wr    (reg_wdata[ST_HALT]),
    .bp_hit     (bp_hit),
    .wp_hit     (wp_hit),
    .wp_precise (dacc_precise),
    .mon_en     (mon_en),
    .halt_en    (halt_en),
    .evt        (dbg_event),
    .entry      (dbg_entry)
  );

  always_comb begin
    status_word = '0;
    status_word[ST_MON]  = mon_en;
    status_word[ST_HALT] = halt_en;
    status_word[ST_ENTRY_LSB +: 4] = dbg_entry;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_op)
      OP_MISC: begin
        if (reg_idx == IDX_IDENT)       reg_rdata = IDENT_WORD;
        else if (reg_idx == IDX_STATUS) reg_rdata = status_word;
      end
      OP_BVAL: reg_rdata = bval_rd;
      OP_BCTL: reg_rdata = bctl_rd;
      OP_WVAL: reg_rdata = wval_rd;
      OP_WCTL: reg_rdata = wctl_rd;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_op,
  input logic [3:0]  reg_idx,
  input logic [31:0] reg_wdata,
  input logic        fetch_valid,
  input logic        dacc_valid,
  input logic        dbg_event,
  input logic [3:0]  dbg_entry,
  input logic        mon_en
);

  AST_EVT_NEEDS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(mon_en)); // R7

  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_op == 3'd0 && reg_idx == 4'd1) |=> (mon_en == $past(reg_wdata[15]))); // R7

  AST_EVT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !dacc_valid) |=> !dbg_event); // R9

  AST_ENTRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> (dbg_entry == 4'h1 || dbg_entry == 4'h2 || dbg_entry == 4'hA)); // R9

  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_event |-> $stable(dbg_entry)); // R10

endmodule

bind dbg_match_unit dbg_match_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_op      (reg_op),
  .reg_idx     (reg_idx),
  .reg_wdata   (reg_wdata),
  .fetch_valid (fetch_valid),
  .dacc_valid  (dacc_valid),
  .dbg_event   (dbg_event),
  .dbg_entry   (dbg_entry),
  .mon_en      (mon_en)
);

// File: tb/dbg_match_unit_tb_top.sv
module dbg_match_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_op;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cpu_user;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        dacc_valid;
  logic [31:0] dacc_addr;
  logic [1:0]  dacc_size;
  logic        dacc_store;
  logic        dacc_precise;
  logic        dbg_event;
  logic [3:0]  dbg_entry;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dbg_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_op(reg_op), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_user(cpu_user),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .dacc_valid(dacc_valid),
    .dacc_addr(dacc_addr), .dacc_size(dacc_size), .dacc_store(dacc_store),
    .dacc_precise(dacc_precise), .dbg_event(dbg_event), .dbg_entry(dbg_entry)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_op = op; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, input logic [3:0] idx, output logic [31:0] d);
    reg_op = op; reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic acc(input logic fv, input logic [31:0] fa, input logic dv,
                     input logic [31:0] da, input logic [1:0] sz, input logic st,
                     input logic pr, input logic us, output logic ev, output logic [3:0] en);
    @(negedge clk);
    fetch_valid = fv; fetch_addr = fa; dacc_valid = dv; dacc_addr = da;
    dacc_size = sz; dacc_store = st; dacc_precise = pr; cpu_user = us;
    @(negedge clk);
    ev = dbg_event; en = dbg_entry;
    fetch_valid = 1'b0; dacc_valid = 1'b0;
  endtask

  function automatic logic mode_pass(input int q, input logic u);
    return (q == 3) || (q == 1 && !u) || (q == 2 && u);
  endfunction

  // watched bytes: value word holds select bits 0..3, next word bits 4..7
  function automatic logic wp_model(input logic [7:0] sel, input int typ, input int w,
                                    input int off, input int sz, input logic st);
    int n;
    logic hit;
    hit = 1'b0;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (st ? typ[1] : typ[0]) begin
      for (int k = 0; k < n; k++) begin
        if (off + k < 4 && w < 2) begin
          if (sel[w*4 + off + k]) hit = 1'b1;
        end
      end
    end
    return hit;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        ev;
    logic [3:0]  en;
    logic [7:0]  sels [7];
    sels[0] = 8'h01; sels[1] = 8'h03; sels[2] = 8'h0F; sels[3] = 8'hF0;
    sels[4] = 8'h30; sels[5] = 8'h80; sels[6] = 8'h0C;

    rst_n = 1'b0; reg_we = 1'b0; reg_op = '0; reg_idx = '0; reg_wdata = '0;
    cpu_user = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; dacc_valid = 1'b0;
    dacc_addr = '0; dacc_size = '0; dacc_store = 1'b0; dacc_precise = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 event", {31'b0, dbg_event}, 32'h0);
    check("R1 entry", {28'b0, dbg_entry}, 32'h0);
    rd(3'd0, 4'd1, d); check("R1 status", d, 32'h0);
    for (int op = 4; op < 8; op++)
      for (int i = 0; i < 4; i++) begin
        rd(3'(op), 4'(i), d); check("R1 pair reg", d, 32'h0);
      end

    // R2 identification word
    rd(3'd0, 4'd0, d); check("R2 ident", d, 32'h1303_0000);
    wr(3'd0, 4'd0, 32'h0);
    rd(3'd0, 4'd0, d); check("R2 ident after write", d, 32'h1303_0000);

    // R3 field layout, readback masks, out-of-range index
    for (int i = 0; i < 4; i++) begin
      wr(3'd4, 4'(i), 32'hFFFF_FFFF); rd(3'd4, 4'(i), d); check("R3 bp value", d, 32'hFFFF_FFFC);
      wr(3'd5, 4'(i), 32'hFFFF_FFFF); rd(3'd5, 4'(i), d); check("R3 bp control", d, 32'h0000_01E7);
    end
    for (int i = 0; i < 2; i++) begin
      wr(3'd6, 4'(i), 32'hFFFF_FFFF); rd(3'd6, 4'(i), d); check("R3 wp value", d, 32'hFFFF_FFFC);
      wr(3'd7, 4'(i), 32'hFFFF_FFFF); rd(3'd7, 4'(i), d); check("R3 wp control", d, 32'h0000_1FFF);
    end
    wr(3'd5, 4'd9, 32'hFFFF_FFFF); rd(3'd5, 4'd9, d); check("R3 bp idx range", d, 32'h0);
    wr(3'd7, 4'd2, 32'hFFFF_FFFF); rd(3'd7, 4'd2, d); check("R3 wp idx range", d, 32'h0);
    rd(3'd2, 4'd0, d); check("R3 reserved op", d, 32'h0);
    for (int op = 4; op < 8; op++)
      for (int i = 0; i < 4; i++) wr(3'(op), 4'(i), 32'h0);

    // monitor on
    wr(3'd0, 4'd1, 32'h0000_8000);
    rd(3'd0, 4'd1, d); check("R7 status monitor", d, 32'h0000_8000);

    // R4 breakpoint sweep: every pair, select pattern, low bits, same/other word
    for (int b = 0; b < 4; b++) begin
      logic [31:0] v;
      v = 32'h0000_1000 + 32'(b) * 32'h40;
      wr(3'd4, 4'(b), v);
      for (int s = 0; s < 16; s++) begin
        wr(3'd5, 4'(b), 32'(s << 5) | 32'h7);
        for (int off = 0; off < 4; off++)
          for (int w = 0; w < 2; w++) begin
            logic expv;
            expv = (w == 0) && s[off];
            acc(1'b1, v + 32'(w * 4 + off), 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0, ev, en);
            check("R4 bp event", {31'b0, ev}, {31'b0, expv});
            if (expv) check("R4 bp entry", {28'b0, en}, 32'h1);
          end
      end
      wr(3'd5, 4'(b), 32'h0);
    end

    // R5 privilege qualifier
    wr(3'd4, 4'd0, 32'h0000_2000);
    for (int q = 0; q < 4; q++)
      for (int u = 0; u < 2; u++) begin
        wr(3'd5, 4'd0, 32'h0000_01E1 | 32'(q << 1));
        acc(1'b1, 32'h0000_2002, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, u[0], ev, en);
        check("R5 privilege", {31'b0, ev}, {31'b0, mode_pass(q, u[0])});
      end

    // R6 watchpoint sweep
    wr(3'd6, 4'd0, 32'h0000_4000);
    for (int p = 0; p < 7; p++)
      for (int t = 0; t < 4; t++) begin
        wr(3'd7, 4'd0, 32'(sels[p]) << 5 | 32'(t << 3) | 32'h7);
        for (int st = 0; st < 2; st++)
          for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++)
              for (int w = 0; w < 3; w++) begin
                logic expv;
                expv = wp_model(sels[p], t, w, off, sz, st[0]);
                acc(1'b0, 32'h0, 1'b1, 32'h0000_4000 + 32'(w * 4 + off), 2'(sz), st[0],
                    off[0], 1'b1, ev, en);
                check("R6 wp event", {31'b0, ev}, {31'b0, expv});
                if (expv) check("R9 wp entry", {28'b0, en}, off[0] ? 32'hA : 32'h2);
              end
      end

    // R9 priority and pulse width
    wr(3'd5, 4'd0, 32'h0000_01E7);
    wr(3'd7, 4'd0, 32'h0000_01FF);
    acc(1'b1, 32'h0000_2000, 1'b1, 32'h0000_4000, 2'd2, 1'b0, 1'b1, 1'b0, ev, en);
    check("R9 both event", {31'b0, ev}, 32'h1);
    check("R9 bp priority", {28'b0, en}, 32'h1);
    @(negedge clk);
    check("R9 single pulse", {31'b0, dbg_event}, 32'h0);
    acc(1'b0, 32'h0, 1'b1, 32'h0000_4001, 2'd0, 1'b1, 1'b0, 1'b0, ev, en);
    check("R9 imprecise code", {28'b0, en}, 32'h2);

    // R10 entry code holds across misses and status writes
    acc(1'b1, 32'h0000_7000, 1'b1, 32'h0000_7000, 2'd2, 1'b0, 1'b1, 1'b0, ev, en);
    check("R10 miss event", {31'b0, ev}, 32'h0);
    check("R10 hold port", {28'b0, en}, 32'h2);
    wr(3'd0, 4'd1, 32'h0000_803C);
    rd(3'd0, 4'd1, d); check("R10 hold status", d, 32'h0000_8008);

    // R7 monitor off blocks events
    wr(3'd0, 4'd1, 32'h0);
    acc(1'b1, 32'h0000_2000, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0, ev, en);
    check("R7 no monitor event", {31'b0, ev}, 32'h0);
    check("R7 no monitor entry", {28'b0, en}, 32'h2);

    // R8 halting locks control registers
    wr(3'd0, 4'd1, 32'h0000_C000);
    wr(3'd5, 4'd1, 32'h0000_01E7); rd(3'd5, 4'd1, d); check("R8 bp ctl locked", d, 32'h0);
    wr(3'd7, 4'd1, 32'h0000_1FFF); rd(3'd7, 4'd1, d); check("R8 wp ctl locked", d, 32'h0);
    wr(3'd4, 4'd1, 32'h0000_3000); rd(3'd4, 4'd1, d); check("R8 value open", d, 32'h0000_3000);
    wr(3'd0, 4'd1, 32'h0000_8000);
    wr(3'd5, 4'd1, 32'h0000_01E7); rd(3'd5, 4'd1, d); check("R8 ctl after unlock", d, 32'h0000_01E7);

    // R11 zero control disables
    wr(3'd5, 4'd0, 32'h0);
    acc(1'b1, 32'h0000_2000, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0, ev, en);
    check("R11 bp disabled", {31'b0, ev}, 32'h0);
    wr(3'd7, 4'd0, 32'h0);
    acc(1'b0, 32'h0, 1'b1, 32'h0000_4000, 2'd2, 1'b1, 1'b1, 1'b0, ev, en);
    check("R11 wp disabled", {31'b0, ev}, 32'h0);
    acc(1'b1, 32'h0000_3001, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, ev, en);
    check("R11 other pair live", {31'b0, ev}, 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule